// File: doc/BRIEF.md
# Two-Port Address Collision Arbiter

This block sits beside a shared memory that has two independent access ports, called left and right. Every clock it compares the two ports. When both are enabled and present the same full address, it decides which port keeps the access and drives a busy indication to the other one. While a port's busy is active, the block removes that port's write strobe, so a write from the losing side never reaches the array. Reads are not gated. The decision uses only enable and address, so it is the same whether the accesses are reads or writes.

Arbitration follows arrival order. A port "arrives" in the cycle its enable rises or its address changes while enabled. The port that has held its address longer wins, and the newcomer gets busy. When both ports arrive in the same cycle, the left port wins. A grant holds for as long as the winning port keeps its address and enable. After the collision ends, the loser's busy stays up for one more cycle.

A mode input selects how the block behaves. In master mode it computes busy itself and drives it out on each port. In slave mode both busy outputs stay low, and a busy input per port acts only as a write inhibit for that port. Several slaves can then follow one master's decision, so a wide word is never split between the two ports.

Top module: `dp_collide_arb`

## Requirements
- R1: In master mode, when in the current cycle and in the cycle before no collision exists (a collision means both enables are high and the addresses are equal), both busy outputs are low.
- R2: When one port already holds an address and the other port arrives at the same address, the arriving port's busy rises in that same cycle. The holding port's busy stays low.
- R3: When both ports arrive at the same address in the same cycle, or both are already there when reset ends, the left port wins and right busy is raised.
- R4: Left busy and right busy are never high together.
- R5: The grant is kept while the winner's enable and address, and the collision, are unchanged, whatever the loser does with its write input.
- R6: In master mode, the loser's busy stays high for exactly one cycle after the collision ends, and is low in the cycle after that.
- R7: A port's gated write equals enable AND write AND NOT blocked. In master mode, blocked is that port's own busy output.
- R8: The read/write input of either port has no effect on either busy output.
- R9: In slave mode, both busy outputs are low, and a high busy input on a port forces that port's gated write low. In master mode the busy inputs have no effect.
- R10: In slave mode, with the busy inputs low, the writes of both ports pass even while the addresses collide.
- R11: While reset (active low) is applied with both ports idle, all outputs are low. Reset clears the grant and the arrival history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_mode | input | 1 | 1 = compute busy here, 0 = take busy from the inputs |
| l_en | input | 1 | Left port enable |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write request |
| l_busy_in | input | 1 | Left write inhibit from outside (slave mode) |
| r_en | input | 1 | Right port enable |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write request |
| r_busy_in | input | 1 | Right write inhibit from outside (slave mode) |
| l_busy_out | output | 1 | Left port lost arbitration |
| r_busy_out | output | 1 | Right port lost arbitration |
| l_wr_gated | output | 1 | Left write strobe toward the array |
| r_wr_gated | output | 1 | Right write strobe toward the array |

## Verification
Busy and the gated writes are combinational outputs of the current inputs and of state captured at the previous edge. A collision therefore shows on busy in the same cycle its inputs are applied, and the tail after a collision ends appears in the next cycle, then clears one cycle later. The bench drives each cycle's inputs just after the falling edge and samples one nanosecond later, well before the next rising edge. It updates its arrival and grant model only after that rising edge, so each compare uses exactly the history the design registered.

// File: rtl/dpa_pkg.sv
// Package: types shared by the collision arbiter modules.
// Assumes: only one port can own a collision at a time.
package dpa_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_L    = 0;
    localparam int unsigned PORT_R    = 1;

endpackage

// File: rtl/dpa_port_track.sv
// Module: remembers one port's enable and address from the previous cycle
// and flags an arrival: the enable has just risen, or the address changed
// while enabled.
// Assumes: enable and address are sampled on the common clock.
module dpa_port_track #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              arrive
);

    logic              en_q;
    logic [ADDR_W-1:0] addr_q;

    // Capture last cycle's enable and address; reset forgets history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    // Arrival: enabled now, and either newly enabled or moved address.
    always_comb begin
        arrive = en && (!en_q || (addr != addr_q));
    end

endmodule

// File: rtl/dpa_grant.sv
// Module: detects a collision and decides which port keeps the access.
// The earlier arrival wins; a tie goes to the left port; a grant is kept
// while the winner stays put. After a collision ends, the loser stays
// flagged for one more cycle.
// Assumes: arrival flags come from dpa_port_track on the same clock.
module dpa_grant
    import dpa_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_arrive,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_arrive,
    output logic              l_lose,
    output logic              r_lose
);

    owner_e owner_q;
    owner_e owner_d;
    logic   collide;

    // Collision: both ports enabled on the same full address.
    always_comb begin
        collide = l_en && r_en && (l_addr == r_addr);
    end

    // Pick this cycle's winner: keep a standing grant, else by arrival order.
    always_comb begin
        if (!collide) begin
            owner_d = OWN_NONE;
        end else if (owner_q == OWN_LEFT && !l_arrive) begin
            owner_d = OWN_LEFT;
        end else if (owner_q == OWN_RIGHT && !r_arrive) begin
            owner_d = OWN_RIGHT;
        end else if (l_arrive && !r_arrive) begin
            owner_d = OWN_RIGHT;
        end else begin
            owner_d = OWN_LEFT;
        end
    end

    // Hold the winner across cycles; reset clears any grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= OWN_NONE;
        end else begin
            owner_q <= owner_d;
        end
    end

    // Loser flags: the live decision, or a one-cycle tail after the collision ends.
    always_comb begin
        l_lose = (owner_d == OWN_RIGHT) || (!collide && owner_q == OWN_RIGHT);
        r_lose = (owner_d == OWN_LEFT)  || (!collide && owner_q == OWN_LEFT);
    end

endmodule

// File: rtl/dpa_wr_gate.sv
// Module: per-port output stage. It selects where busy comes from (own
// decision or external inhibit) and strips the write strobe when blocked.
// Assumes: busy_in matters only when master_mode is low.
module dpa_wr_gate (
    input  logic master_mode,
    input  logic en,
    input  logic wr,
    input  logic lose,
    input  logic busy_in,
    output logic busy_out,
    output logic wr_gated
);

    logic blocked;

    // Source of the inhibit depends on the mode.
    always_comb begin
        blocked  = master_mode ? lose : busy_in;
        busy_out = master_mode && lose;
        wr_gated = en && wr && !blocked;
    end

endmodule

// File: rtl/dp_collide_arb.sv
// Module: top of the two-port address collision arbiter. It tracks both
// ports' arrivals, arbitrates equal-address accesses, and gates the losing
// port's write.
// Assumes: both ports share one clock; enables and writes are active high.
module dp_collide_arb
    import dpa_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic              l_busy_in,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr,
    input  logic              r_busy_in,
    output logic              l_busy_out,
    output logic              r_busy_out,
    output logic              l_wr_gated,
    output logic              r_wr_gated
);

    logic [NUM_PORTS-1:0]             en_v;
    logic [NUM_PORTS-1:0]             wr_v;
    logic [NUM_PORTS-1:0]             bin_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0]             arrive_v;
    logic [NUM_PORTS-1:0]             lose_v;
    logic [NUM_PORTS-1:0]             bout_v;
    logic [NUM_PORTS-1:0]             wgate_v;

    // Gather the port signals into vectors indexed by port.
    always_comb begin
        en_v[PORT_L]   = l_en;
        en_v[PORT_R]   = r_en;
        wr_v[PORT_L]   = l_wr;
        wr_v[PORT_R]   = r_wr;
        bin_v[PORT_L]  = l_busy_in;
        bin_v[PORT_R]  = r_busy_in;
        addr_v[PORT_L] = l_addr;
        addr_v[PORT_R] = r_addr;
    end

    // One arrival tracker and one output stage per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_v[p]),
            .addr   (addr_v[p]),
            .arrive (arrive_v[p])
        );

        dpa_wr_gate u_gate (
            .master_mode (master_mode),
            .en          (en_v[p]),
            .wr          (wr_v[p]),
            .lose        (lose_v[p]),
            .busy_in     (bin_v[p]),
            .busy_out    (bout_v[p]),
            .wr_gated    (wgate_v[p])
        );
    end

    dpa_grant #(.ADDR_W(ADDR_W)) u_grant (
        .clk      (clk),
        .rst_n    (rst_n),
        .l_en     (en_v[PORT_L]),
        .l_addr   (addr_v[PORT_L]),
        .l_arrive (arrive_v[PORT_L]),
        .r_en     (en_v[PORT_R]),
        .r_addr   (addr_v[PORT_R]),
        .r_arrive (arrive_v[PORT_R]),
        .l_lose   (lose_v[PORT_L]),
        .r_lose   (lose_v[PORT_R])
    );

    // Drive the per-port results back out.
    always_comb begin
        l_busy_out = bout_v[PORT_L];
        r_busy_out = bout_v[PORT_R];
        l_wr_gated = wgate_v[PORT_L];
        r_wr_gated = wgate_v[PORT_R];
    end

endmodule

// File: rtl/dpa_collide_chk.sv
// Module: property checker for dp_collide_arb, attached by bind below.
// Assumes: it is connected to the top module's ports only.
module dpa_collide_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              l_en,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_wr,
    input logic              l_busy_in,
    input logic              r_en,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_wr,
    input logic              r_busy_in,
    input logic              l_busy_out,
    input logic              r_busy_out,
    input logic              l_wr_gated,
    input logic              r_wr_gated
);

    logic same;

    // Collision as seen at the ports.
    always_comb begin
        same = l_en && r_en && (l_addr == r_addr);
    end

    // R4: the two busy outputs never rise together.
    p_busy_mutex_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_busy_out && r_busy_out));

    // R1: without a collision now and one cycle back, no busy.
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!same) ##1 (!same && master_mode) |-> (!l_busy_out && !r_busy_out));

    // R7: a busy port in master mode never writes.
    p_gate_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && l_busy_out) |-> !l_wr_gated);
    p_gate_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && r_busy_out) |-> !r_wr_gated);

    // R9: slave mode keeps busy outputs low and honours the inhibit inputs.
    p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (!l_busy_out && !r_busy_out));
    p_slave_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && (l_busy_in || r_busy_in)) |->
        ((!l_busy_in || !l_wr_gated) && (!r_busy_in || !r_wr_gated)));

    // R5: an unchanged collision keeps the same loser.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && same && r_busy_out) ##1
        (master_mode && same && $stable(l_addr) && $stable(r_addr)) |-> r_busy_out);

    // R6: the loser stays busy for one cycle after the collision ends.
    p_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && same && l_busy_out) ##1 (master_mode && !same) |-> l_busy_out);

endmodule

bind dp_collide_arb dpa_collide_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .l_en        (l_en),
    .l_addr      (l_addr),
    .l_wr        (l_wr),
    .l_busy_in   (l_busy_in),
    .r_en        (r_en),
    .r_addr      (r_addr),
    .r_wr        (r_wr),
    .r_busy_in   (r_busy_in),
    .l_busy_out  (l_busy_out),
    .r_busy_out  (r_busy_out),
    .l_wr_gated  (l_wr_gated),
    .r_wr_gated  (r_wr_gated)
);

// File: tb/test_dp_collide_arb.sv
// Bench: directed sequences per requirement, then a long pseudo-random
// sweep over a 2-bit address space, compared with a bench-side model.
module test_dp_collide_arb;

    localparam int unsigned AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_mode = 1'b1;
    logic          l_en = 1'b0, r_en = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
    logic          l_busy_in = 1'b0, r_busy_in = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_out, r_busy_out, l_wr_gated, r_wr_gated;

    int tests = 0;
    int fails = 0;

    // Model state: previous enables/addresses and standing owner (0 none, 1 left, 2 right).
    bit          m_len, m_ren;
    bit [AW-1:0] m_la, m_ra;
    int          m_own;

    always #2.5 clk = ~clk;

    dp_collide_arb #(.ADDR_W(AW)) i_dp_collide_arb (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr), .l_busy_in(l_busy_in),
        .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr), .r_busy_in(r_busy_in),
        .l_busy_out(l_busy_out), .r_busy_out(r_busy_out),
        .l_wr_gated(l_wr_gated), .r_wr_gated(r_wr_gated)
    );

    task automatic check(input bit act, input bit exp, input string what, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive after the falling edge, compare, then advance the model.
    task automatic cyc(input bit mst,
                       input bit len, input bit [AW-1:0] la, input bit lwr, input bit lbi,
                       input bit ren, input bit [AW-1:0] ra, input bit rwr, input bit rbi,
                       input string tag);
        bit m, ln, rn, elb, erb, lblk, rblk;
        int win;
        @(negedge clk);
        master_mode = mst;
        l_en = len; l_addr = la; l_wr = lwr; l_busy_in = lbi;
        r_en = ren; r_addr = ra; r_wr = rwr; r_busy_in = rbi;
        #1;
        m  = len && ren && (la == ra);
        ln = len && (!m_len || la != m_la);
        rn = ren && (!m_ren || ra != m_ra);
        if (!m)                     win = 0;
        else if (m_own == 1 && !ln) win = 1;
        else if (m_own == 2 && !rn) win = 2;
        else if (ln && !rn)         win = 2;
        else                        win = 1;
        elb  = mst && (win == 2 || (!m && m_own == 2));
        erb  = mst && (win == 1 || (!m && m_own == 1));
        lblk = mst ? elb : lbi;
        rblk = mst ? erb : rbi;
        check(l_busy_out, elb, "l_busy_out", tag);
        check(r_busy_out, erb, "r_busy_out", tag);
        check(l_wr_gated, len && lwr && !lblk, "l_wr_gated", tag);
        check(r_wr_gated, ren && rwr && !rblk, "r_wr_gated", tag);
        @(posedge clk);
        m_len = len; m_la = la; m_ren = ren; m_ra = ra; m_own = win;
    endtask

    task automatic idle(input string tag);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(5.0 * 190000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit [15:0] lf;
        m_len = 0; m_ren = 0; m_la = 0; m_ra = 0; m_own = 0;
        // R11: reset with idle ports gives all outputs low.
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(l_busy_out, 0, "l_busy_out", "R11");
        check(r_busy_out, 0, "r_busy_out", "R11");
        check(l_wr_gated, 0, "l_wr_gated", "R11");
        check(r_wr_gated, 0, "r_wr_gated", "R11");
        // R11/R3: both present at reset release count as simultaneous.
        l_en = 1; r_en = 1; l_addr = 2; r_addr = 2;
        @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        check(r_busy_out, 1, "r_busy_out", "R11");
        check(l_busy_out, 0, "l_busy_out", "R11");
        @(posedge clk);
        m_len = 1; m_ren = 1; m_la = 2; m_ra = 2; m_own = 1;
        idle("R6"); idle("R1");

        // R1: different addresses, or one side disabled.
        cyc(1, 1, 1, 1, 0, 1, 2, 1, 0, "R1");
        cyc(1, 1, 3, 1, 0, 0, 3, 1, 0, "R1");
        cyc(1, 0, 3, 1, 0, 1, 3, 1, 0, "R1");
        idle("R1");

        // R2: left holds first, right arrives; then the reverse.
        cyc(1, 1, 1, 0, 0, 0, 0, 0, 0, "R2");
        cyc(1, 1, 1, 0, 0, 1, 1, 1, 0, "R2");
        cyc(1, 1, 1, 1, 0, 1, 1, 1, 0, "R7");
        cyc(1, 1, 1, 0, 0, 1, 1, 0, 0, "R5");
        cyc(1, 1, 1, 1, 0, 1, 1, 1, 0, "R5");
        cyc(1, 1, 0, 0, 0, 1, 1, 1, 0, "R6");
        cyc(1, 1, 0, 0, 0, 1, 1, 1, 0, "R6");
        idle("R1");
        cyc(1, 0, 0, 0, 0, 1, 2, 0, 0, "R2");
        cyc(1, 1, 2, 1, 0, 1, 2, 0, 0, "R2");
        cyc(1, 1, 2, 1, 0, 1, 2, 1, 0, "R7");
        cyc(1, 1, 2, 1, 0, 0, 2, 1, 0, "R6");
        idle("R6");

        // R3: simultaneous arrival goes to the left.
        cyc(1, 1, 3, 1, 0, 1, 3, 1, 0, "R3");
        cyc(1, 1, 3, 0, 0, 1, 3, 1, 0, "R5");
        idle("R6"); idle("R1");

        // R8: write inputs do not change the decision.
        cyc(1, 0, 0, 0, 0, 1, 0, 1, 0, "R8");
        cyc(1, 1, 0, 0, 0, 1, 0, 1, 0, "R8");
        cyc(1, 1, 0, 1, 0, 1, 0, 0, 0, "R8");
        idle("R8"); idle("R8");

        // R9: master ignores busy inputs; slave honours them.
        cyc(1, 1, 1, 1, 1, 1, 2, 1, 1, "R9");
        cyc(0, 1, 1, 1, 1, 1, 2, 1, 0, "R9");
        cyc(0, 1, 1, 1, 0, 1, 2, 1, 1, "R9");
        // R10: slave collision with inhibits low lets both writes pass.
        cyc(0, 1, 3, 1, 0, 1, 3, 1, 0, "R10");
        cyc(0, 1, 3, 1, 0, 1, 3, 1, 0, "R10");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
        idle("R1"); idle("R1");

        // R4/R2: pseudo-random sweep over all input combinations.
        lf = 16'hACE1;
        for (int i = 0; i < 30000; i++) begin
            bit mst;
            lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            mst = ((i / 700) % 4) != 3;
            cyc(mst, lf[0] | lf[9], lf[2:1], lf[3], lf[4],
                lf[5] | lf[10], lf[7:6], lf[8], lf[11],
                mst ? "R4" : "R9");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule